// File: doc/BRIEF.md
# Ping-Pong Stream Receive Buffer with Sender Back-Pressure

The block takes a one-word-per-cycle stream from a link and stores it in two receive buffers that are used alternately. Each buffer can be read by software over a small register bus while the link fills the other one. When a buffer fills, it is marked full, a pending interrupt is latched for it, and filling moves on to the other buffer. Software drains a full buffer, usually by DMA, and then writes that buffer's release bit. The release empties the buffer and hands it back to the link.

A wait line tells the sender to pause. It is computed from the free space left in both buffers together and rises while two word slots are still free, so the words already in flight at the sender still land. Wait falls again as soon as a release frees enough space. A word that arrives with no slot left is discarded, and it sets a sticky overflow flag.

Top module: `stream_rx_pingpong`

## Requirements
- R1: After reset, both word counts are 0, no buffer is full, no interrupt is pending, the overflow flag is 0, the fill target is buffer 0, `link_wait` is low and `irq` is low.
- R2: Each accepted word is written into the current fill target at the index equal to that buffer's count before the write, and the count then goes up by one. Words are stored in arrival order starting at index 0.
- R3: When a buffer's count reaches DEPTH, it is flagged full and the fill target switches to the other buffer.
- R4: A buffer becoming full sets its pending bit. `irq` is high while either pending bit is set. Writing 1 to a buffer's acknowledge bit clears that pending bit alone.
- R5: `link_wait` is high exactly when the free slots summed over both buffers are SLACK (default 2) or fewer. Words arriving while wait is high are still accepted while a slot is free.
- R6: A word arriving while both buffers are full is discarded and leaves counts and contents unchanged. It sets a sticky overflow flag, which stays set until a write of 1 to the overflow-clear bit.
- R7: Writing 1 to a buffer's release bit clears its count and full flag. If both buffers were full, the released buffer becomes the fill target.
- R8: Bus reads return data on `bus_rdata` in the cycle after `bus_rd`. With the address MSB at 1, the next bit picks the buffer and the low log2(DEPTH) bits pick the word. With the MSB at 0, the low two bits select: 0 status, 1 count of buffer 0, 2 count of buffer 1, 3 control (write only, reads 0). The status bits are: 0/1 full of buffer 0/1, 2/3 pending of buffer 0/1, 4 overflow, 5 fill target, 6 wait. The control bits are: 0/1 release of buffer 0/1, 2/3 acknowledge of buffer 0/1, 4 overflow clear.
- R9: Releasing the buffer that is partly filled and is the current target discards its words. The target is unchanged and the next word goes to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A link word is present this cycle |
| in_data | input | DATA_W | Link word |
| link_wait | output | 1 | Back-pressure to the sender |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | log2(DEPTH)+2 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the strobe |
| irq | output | 1 | Interrupt, high while any buffer event is pending |

## Verification
The link is driven with a steady run of words that fills buffer 0, crosses into buffer 1 and ends with both full. After every word, the counts, the target and wait are compared against a table, which separates a wrong fill index, a late target switch and a wait threshold that is off by one. Extra words pushed into two full buffers separate discard from overwrite. The release patterns separate three cases: a release while both buffers are full, which must move the target; a release of a partly filled target, which must restart at index 0; and a single acknowledgement, which must leave the other pending bit alone.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned NBUF = 2;

  // register selects when the window bit is clear
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CNT0   = 2'd1,
    SEL_CNT1   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int unsigned ST_FULL = 0;  // two bits
  localparam int unsigned ST_PEND = 2;  // two bits
  localparam int unsigned ST_OVF  = 4;
  localparam int unsigned ST_TGT  = 5;
  localparam int unsigned ST_WAIT = 6;
  localparam int unsigned ST_W    = 7;

  // control bit positions
  localparam int unsigned CT_REL  = 0;  // two bits
  localparam int unsigned CT_ACK  = 2;  // two bits
  localparam int unsigned CT_OVFC = 4;
endpackage

// File: rtl/rxs_buf.sv
module rxs_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/rxs_fill.sv
module rxs_fill
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [NBUF-1:0]            rel,
  input  logic [NBUF-1:0]            ack,
  input  logic                       ovf_clr,
  output logic [NBUF-1:0]            wr_en,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [NBUF-1:0][CNT_W-1:0] cnt,
  output logic [NBUF-1:0]            full,
  output logic [NBUF-1:0]            pend,
  output logic                       ovf,
  output logic                       tgt,
  output logic                       link_wait
);
  logic [NBUF-1:0][CNT_W-1:0] cnt_q, cnt_n;
  logic [NBUF-1:0]            pend_q, pend_n;
  logic                       ovf_q, ovf_n;
  logic                       tgt_q, tgt_n;
  logic                       state_en;
  logic [CNT_W:0]             free_sum;

  always_comb begin
    for (int b = 0; b < NBUF; b++) full[b] = (cnt_q[b] == CNT_W'(DEPTH));
  end

  always_comb begin
    free_sum = '0;
    for (int b = 0; b < NBUF; b++)
      free_sum = free_sum + ((CNT_W+1)'(DEPTH) - {1'b0, cnt_q[b]});
  end

  // next state
  always_comb begin
    cnt_n  = cnt_q;
    tgt_n  = tgt_q;
    pend_n = pend_q & ~ack;
    ovf_n  = ovf_q & ~ovf_clr;
    wr_en  = '0;
    wr_idx = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (rel[b]) cnt_n[b] = '0;
    end
    if (in_valid && full[tgt_q]) ovf_n = 1'b1;
    if (in_valid && !full[tgt_q]) begin
      wr_en[tgt_q]  = 1'b1;
      wr_idx        = cnt_n[tgt_q][IDX_W-1:0];
      cnt_n[tgt_q]  = cnt_n[tgt_q] + 1'b1;
      if (cnt_n[tgt_q] == CNT_W'(DEPTH)) begin
        pend_n[tgt_q] = 1'b1;
        tgt_n         = ~tgt_q;
      end
    end else if (full[tgt_q] && (|rel)) begin
      tgt_n = rel[tgt_q] ? tgt_q : ~tgt_q;
    end
  end

  assign state_en = in_valid | (|rel) | (|ack) | ovf_clr;

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
      tgt_q  <= 1'b0;
    end else if (state_en) begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      ovf_q  <= ovf_n;
      tgt_q  <= tgt_n;
    end
  end

  assign cnt       = cnt_q;
  assign pend      = pend_q;
  assign ovf       = ovf_q;
  assign tgt       = tgt_q;
  assign link_wait = (free_sum <= (CNT_W+1)'(SLACK));

  // R6: the target can only be full when every buffer is full
  a_r6_target_full_means_all: assert property (@(posedge clk) disable iff (!rst_n)
    full[tgt_q] |-> (&full));

  // R5/R6: overflow can only appear after the sender was told to wait
  a_r6_ovf_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(link_wait));

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CNT_W'(DEPTH));
    a_r4_full_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[g]) |-> pend_q[g]);
    a_r7_release_empties: assert property (@(posedge clk) disable iff (!rst_n)
      rel[g] |=> (cnt_q[g] <= CNT_W'(1)));
  end
endmodule

// File: rtl/rxs_csr.sv
module rxs_csr
  import rxs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [ST_W-1:0]            status,
  input  logic [NBUF-1:0][CNT_W-1:0] cnt,
  output logic [NBUF-1:0]            rel,
  output logic [NBUF-1:0]            ack,
  output logic                       ovf_clr,
  output logic                       buf_rd_en,
  output logic [IDX_W-1:0]           buf_rd_idx,
  input  logic [NBUF-1:0][DATA_W-1:0] buf_rd_data
);
  logic              win;
  reg_sel_e          sel;
  logic              ctrl_wr;
  logic [DATA_W-1:0] reg_n, reg_q;
  logic              win_q, bsel_q;

  assign win        = bus_addr[ADDR_W-1];
  assign sel        = reg_sel_e'(bus_addr[1:0]);
  assign ctrl_wr    = bus_wr && !win && (sel == SEL_CTRL);
  assign rel        = ctrl_wr ? bus_wdata[CT_REL +: NBUF] : '0;
  assign ack        = ctrl_wr ? bus_wdata[CT_ACK +: NBUF] : '0;
  assign ovf_clr    = ctrl_wr && bus_wdata[CT_OVFC];
  assign buf_rd_en  = bus_rd && win;
  assign buf_rd_idx = bus_addr[IDX_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_n = DATA_W'(status);
      SEL_CNT0:   reg_n = DATA_W'(cnt[0]);
      SEL_CNT1:   reg_n = DATA_W'(cnt[1]);
      default:    reg_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      win_q  <= 1'b0;
      bsel_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q  <= reg_n;
      win_q  <= win;
      bsel_q <= bus_addr[ADDR_W-2];
    end
  end

  assign bus_rdata = win_q ? buf_rd_data[bsel_q] : reg_q;

  // R8: control pulses exist only in a bus write cycle
  a_r8_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rel) || (|ack) || ovf_clr) |-> bus_wr);
endmodule

// File: rtl/stream_rx_pingpong.sv
module stream_rx_pingpong
  import rxs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int SLACK  = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              link_wait,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]                 rst_sync;
  logic                       core_rst_n;
  logic [NBUF-1:0]            wr_en, rel, ack, full, pend;
  logic [IDX_W-1:0]           wr_idx, rd_idx;
  logic [NBUF-1:0][CNT_W-1:0] cnt;
  logic                       ovf, tgt, ovf_clr, rd_en;
  logic [NBUF-1:0][DATA_W-1:0] rd_data;
  logic [ST_W-1:0]            status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  rxs_fill #(.DEPTH(DEPTH), .SLACK(SLACK)) u_fill (
    .clk(clk), .rst_n(core_rst_n), .in_valid(in_valid),
    .rel(rel), .ack(ack), .ovf_clr(ovf_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .cnt(cnt), .full(full),
    .pend(pend), .ovf(ovf), .tgt(tgt), .link_wait(link_wait)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    rxs_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .wr_en(wr_en[g]), .wr_idx(wr_idx), .wr_data(in_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data[g])
    );
  end

  always_comb begin
    status                   = '0;
    status[ST_FULL +: NBUF]  = full;
    status[ST_PEND +: NBUF]  = pend;
    status[ST_OVF]           = ovf;
    status[ST_TGT]           = tgt;
    status[ST_WAIT]          = link_wait;
  end

  rxs_csr #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_csr (
    .clk(clk), .rst_n(core_rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status(status), .cnt(cnt), .rel(rel), .ack(ack), .ovf_clr(ovf_clr),
    .buf_rd_en(rd_en), .buf_rd_idx(rd_idx), .buf_rd_data(rd_data)
  );

  assign irq = |pend;

  // R4: an interrupt never appears without a buffer having filled
  a_r4_irq_from_fill: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(irq) |-> (|full));
endmodule

// File: tb/stream_rx_pingpong_bench.sv
module stream_rx_pingpong_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DP = 4;
  localparam int AW = $clog2(DP) + 2;

  // data, count0, count1, wait, target after each pushed word
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{16'hA001, 1, 0, 0, 0},
    '{16'hA002, 2, 0, 0, 0},
    '{16'hA003, 3, 0, 0, 0},
    '{16'hA004, 4, 0, 0, 1},
    '{16'hB001, 4, 1, 0, 1},
    '{16'hB002, 4, 2, 1, 1},
    '{16'hB003, 4, 3, 1, 1},
    '{16'hB004, 4, 4, 1, 0}
  };

  logic clk, rst_n, in_valid, link_wait, bus_rd, bus_wr, irq;
  logic [DW-1:0] in_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  int total, bad;
  bit done;
  logic [DW-1:0] v;

  stream_rx_pingpong #(.DATA_W(DW), .DEPTH(DP), .SLACK(2)) u_stream_rx_pingpong (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .link_wait(link_wait), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; in_valid = 0; in_data = '0;
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 wait", link_wait, 0);
    chk("R1 irq", irq, 0);
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 count0", v, 0);
    rd(2, v); chk("R1 count1", v, 0);

    // R2 R3 R5 table walk
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][0][DW-1:0]);
      chk("R5 wait", link_wait, VEC[i][3]);
      rd(0, v); chk("R3 target", v[5], VEC[i][4]);
      rd(1, v); chk("R2 count0", v, VEC[i][1]);
      rd(2, v); chk("R2 count1", v, VEC[i][2]);
    end

    // R4 both pending, R8 status layout
    chk("R4 irq", irq, 1);
    rd(0, v); chk("R8 status both full", v, 16'h4F);
    rd(8, v);  chk("R2 buf0 idx0", v, 16'hA001);
    rd(11, v); chk("R2 buf0 idx3", v, 16'hA004);
    rd(14, v); chk("R2 buf1 idx2", v, 16'hB003);
    rd(3, v);  chk("R8 control reads zero", v, 0);

    // R6 overflow
    push(16'hDEAD);
    rd(0, v); chk("R6 ovf status", v, 16'h5F);
    rd(2, v); chk("R6 count1 kept", v, 4);
    rd(8, v); chk("R6 buf0 idx0 kept", v, 16'hA001);
    rd(12, v); chk("R6 buf1 idx0 kept", v, 16'hB001);

    // R4 single acknowledge
    wr(3, 16'h04);
    chk("R4 irq after ack0", irq, 1);
    rd(0, v); chk("R4 ack0 only", v, 16'h5B);
    wr(3, 16'h08);
    chk("R4 irq after ack1", irq, 0);
    wr(3, 16'h10);
    rd(0, v); chk("R6 ovf cleared", v, 16'h43);

    // R7 release while both full
    wr(3, 16'h02);
    chk("R7 wait drops", link_wait, 0);
    rd(0, v); chk("R7 target moves", v, 16'h21);
    rd(2, v); chk("R7 count1 zero", v, 0);
    push(16'hC001);
    push(16'hC002);
    chk("R5 wait at slack", link_wait, 1);
    rd(13, v); chk("R2 buf1 idx1", v, 16'hC002);

    // R9 release of partly filled target
    wr(3, 16'h02);
    chk("R9 wait low", link_wait, 0);
    rd(0, v); chk("R9 target kept", v, 16'h21);
    push(16'hD001);
    rd(12, v); chk("R9 restart idx0", v, 16'hD001);
    rd(2, v);  chk("R9 count1", v, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule